// File: doc/BRIEF.md
# Bit-Stream Alignment Parser

This block sits between the stream of compressed 32-bit words and a symbol decoder that works on single bits. Words enter through a small input queue. Each word can be byte-swapped on entry, so data in either byte order is read as one continuous bit stream. A bit reservoir always holds the oldest unconsumed bits. Bit 0 of the window output is the next bit in the stream. The decoder names how many bits its current lookup needs and receives a valid flag. It then reports how many bits it actually used, and the reservoir drops exactly that many.

The reservoir reloads a whole word from the queue whenever it has room for one, so a code can straddle any word boundary. An align command skips the remaining bits of the current byte, which byte-aligned payloads require. If the source signals that no more words will come and the bits left cannot satisfy the pending request, a sticky underflow flag is raised.

Top module: `bitstream_aligner`

## Requirements
- R1: After a synchronous active-high reset the reservoir is empty. `win_data` is 0, `win_valid` is low for any nonzero `need_n`, `in_ready` is high and `err_underflow` is low.
- R2: The input queue holds 16 words and the reservoir holds two more. With no bits consumed, exactly 18 words are accepted before `in_ready` goes low, and it stays low.
- R3: Bits are taken from each stored word LSB first, and words are taken in arrival order. `win_data[i]` is the i-th unconsumed bit of the stream, and every bit above the number held in the reservoir reads 0. With `big_endian` low, incoming byte k is `in_data[8k+7:8k]`.
- R4: When `use_ack` is high, the window moves forward by exactly `use_n` bits (0 to 16) at the next clock edge. A `use_n` of 0 leaves it unchanged.
- R5: The reservoir loads a full queued word only when it holds 32 bits or fewer. Across any number of reloads no bit is lost or repeated.
- R6: `win_valid` is high exactly when the reservoir holds at least `need_n` bits. `use_ack` is combinational and is high only when `use_en` is high, `align_en` is low and `use_n` does not exceed the bits held. A request that is not acknowledged shifts nothing and may be repeated after a refill.
- R7: `align_en` discards bits until the window starts on a byte boundary of the stream. It takes priority over `use_en` in the same cycle, and that use is not acknowledged.
- R8: With `src_done` high, the queue empty and fewer bits held than `need_n`, `err_underflow` is set at the next edge. It then stays set until reset.
- R9: With `big_endian` high at the time a word is accepted, byte k of the stream is `in_data[31-8k:24-8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Byte order of words being accepted (1 = first byte in the top lane) |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Queue can take a word this cycle |
| src_done | input | 1 | No further words will arrive |
| need_n | input | 5 | Bits the current lookup needs |
| win_data | output | 16 | Next unconsumed bits, LSB first |
| win_valid | output | 1 | At least `need_n` bits held |
| use_en | input | 1 | Consume request |
| use_n | input | 5 | Bits to consume (0 to 16) |
| use_ack | output | 1 | Consume request accepted this cycle |
| align_en | input | 1 | Skip to the next byte boundary |
| err_underflow | output | 1 | Sticky: input ended with too few bits |

## Verification
The hardest state to reach is a reservoir holding a few bits that cannot satisfy the request, with the queue empty. Reaching it takes exact draining: the bench loads one word, consumes 16 and then 12 bits to leave 4, and probes a refused 9-bit use there. A second word is then fed, and the window is expected to splice the old 4 bits under the new word. After that, the reservoir is drained to 11 bits before `src_done` is raised. This shows the underflow flag separating a request that fits from one that does not.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  // source of the reservoir shift in a given cycle
  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_USE   = 2'd1,
    SH_ALIGN = 2'd2
  } sh_src_e;
endpackage

// File: rtl/bsa_byte_order.sv
module bsa_byte_order #(
  parameter int WORD_W = 32
) (
  input  logic              big_en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NB = WORD_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = big_en ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/bsa_fifo.sv
module bsa_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bitstream_aligner.sv
module bitstream_aligner
  import bsa_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int WIN_W      = 16,
  localparam int CNT_W     = $clog2(WIN_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              big_endian,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              src_done,
  input  logic [CNT_W-1:0]  need_n,
  output logic [WIN_W-1:0]  win_data,
  output logic              win_valid,
  input  logic              use_en,
  input  logic [CNT_W-1:0]  use_n,
  output logic              use_ack,
  input  logic              align_en,
  output logic              err_underflow
);
  localparam int RES_W = 2 * WORD_W;
  localparam int LVL_W = $clog2(RES_W + 1);

  logic [WORD_W-1:0] word_norm, fifo_q;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [RES_W-1:0]  res, res_next;
  logic [LVL_W-1:0]  level, lvl_after, sh_amt;
  sh_src_e           sh_sel;

  bsa_byte_order #(.WORD_W(WORD_W)) u_order (
    .big_en (big_endian),
    .din    (in_data),
    .dout   (word_norm)
  );

  bsa_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (in_valid),
    .wr_data (word_norm),
    .full    (fifo_full),
    .rd_en   (fifo_pop),
    .rd_data (fifo_q),
    .empty   (fifo_empty)
  );

  assign in_ready  = !fifo_full;
  // reload only when a whole word fits above the held bits
  assign fifo_pop  = !fifo_empty && (level <= LVL_W'(WORD_W));
  assign use_ack   = use_en && !align_en && (LVL_W'(use_n) <= level);
  assign win_data  = res[WIN_W-1:0];
  assign win_valid = (LVL_W'(need_n) <= level);

  always_comb begin
    if (align_en)     sh_sel = SH_ALIGN;
    else if (use_ack) sh_sel = SH_USE;
    else              sh_sel = SH_NONE;
    case (sh_sel)
      SH_ALIGN: sh_amt = LVL_W'(level[2:0]);
      SH_USE:   sh_amt = LVL_W'(use_n);
      default:  sh_amt = '0;
    endcase
    lvl_after = level - sh_amt;
    res_next  = res >> sh_amt;
    if (fifo_pop) res_next = res_next | (RES_W'(fifo_q) << lvl_after);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res           <= '0;
      level         <= '0;
      err_underflow <= 1'b0;
    end else begin
      res   <= res_next;
      level <= lvl_after + (fifo_pop ? LVL_W'(WORD_W) : '0);
      if (src_done && fifo_empty && (LVL_W'(need_n) > level))
        err_underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int WORD_W = 32,
  parameter int WIN_W  = 16,
  parameter int RES_W  = 64,
  parameter int LVL_W  = 7,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [RES_W-1:0] res,
  input logic [LVL_W-1:0] level,
  input logic             fifo_pop,
  input logic             use_en,
  input logic             use_ack,
  input logic             align_en,
  input logic             err_underflow
);
  AST_ZERO_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (res >> level) == '0); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(RES_W)); // R5

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> level >= LVL_W'(WORD_W)); // R5

  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (use_en && !use_ack && !align_en && !fifo_pop) |=> level == $past(level)); // R6

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    align_en |=> level[2:0] == 3'd0); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_underflow |=> err_underflow); // R8
endmodule

bind bitstream_aligner bsa_checker #(
  .WORD_W(WORD_W), .WIN_W(WIN_W), .RES_W(RES_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .res           (res),
  .level         (level),
  .fifo_pop      (fifo_pop),
  .use_en        (use_en),
  .use_ack       (use_ack),
  .align_en      (align_en),
  .err_underflow (err_underflow)
);

// File: tb/bitstream_aligner_tb.sv
module bitstream_aligner_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        src_done = 1'b0;
  logic [4:0]  need_n = '0;
  logic [15:0] win_data;
  logic        win_valid;
  logic        use_en = 1'b0;
  logic [4:0]  use_n = '0;
  logic        use_ack;
  logic        align_en = 1'b0;
  logic        err_underflow;

  int checks = 0;
  int failures = 0;
  logic [1023:0] stream;
  int ptr;

  localparam int NSTEP = 10;
  localparam int STEP_N [NSTEP] = '{0, 9, 16, 3, 7, 1, 12, 5, 16, 8};

  always #2 clk = ~clk;

  bitstream_aligner u_dut (
    .clk(clk), .rst(rst), .big_endian(big_endian), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .src_done(src_done),
    .need_n(need_n), .win_data(win_data), .win_valid(win_valid),
    .use_en(use_en), .use_n(use_n), .use_ack(use_ack),
    .align_en(align_en), .err_underflow(err_underflow)
  );

  function automatic logic [31:0] word_of(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_done = 1'b0; need_n = '0; use_en = 1'b0; align_en = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] w);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic consume(input int n, input string req);
    use_en = 1'b1; use_n = 5'(n);
    #1 chk(req, {31'd0, use_ack}, 32'd1);
    @(negedge clk);
    use_en = 1'b0;
    ptr += n;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int acc;
    do_reset();
    // R1 reset state
    need_n = 5'd1;
    #1;
    chk("R1 win_data", {16'd0, win_data}, 32'd0);
    chk("R1 win_valid", {31'd0, win_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 err", {31'd0, err_underflow}, 32'd0);

    // R2 capacity with no consumption
    acc = 0;
    for (int i = 0; i < 30; i++) begin
      if (!in_ready) break;
      in_valid = 1'b1; in_data = word_of(acc);
      stream[32*acc +: 32] = word_of(acc);
      @(negedge clk);
      acc++;
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 accepted words", acc, 32'd18);
    chk("R2 in_ready low", {31'd0, in_ready}, 32'd0);

    // R3 R4 R5 table of consume steps against the bench bit stream
    ptr = 0;
    chk("R3 first window", {16'd0, win_data}, {16'd0, stream[0 +: 16]});
    for (int s = 0; s < NSTEP; s++) begin
      consume(STEP_N[s], "R4 ack");
      chk("R4 R5 window after step", {16'd0, win_data}, {16'd0, stream[ptr +: 16]});
    end

    // R7 align, then align taking priority over a use
    align_en = 1'b1;
    @(negedge clk);
    align_en = 1'b0;
    ptr = (ptr + 7) & ~7;
    repeat (2) @(negedge clk);
    chk("R7 aligned window", {16'd0, win_data}, {16'd0, stream[ptr +: 16]});
    consume(3, "R4 ack");
    align_en = 1'b1; use_en = 1'b1; use_n = 5'd9;
    #1 chk("R7 use refused during align", {31'd0, use_ack}, 32'd0);
    @(negedge clk);
    align_en = 1'b0; use_en = 1'b0;
    ptr = (ptr + 7) & ~7;
    repeat (2) @(negedge clk);
    chk("R7 align priority window", {16'd0, win_data}, {16'd0, stream[ptr +: 16]});

    // R6 hold on short reservoir
    do_reset();
    use_en = 1'b1; use_n = 5'd5;
    #1 chk("R6 refused on empty", {31'd0, use_ack}, 32'd0);
    @(negedge clk);
    use_en = 1'b0;
    push(32'hC0DE_F00D);
    repeat (3) @(negedge clk);
    need_n = 5'd16;
    #1 chk("R6 valid with 32 held", {31'd0, win_valid}, 32'd1);
    consume(16, "R4 ack");
    consume(12, "R4 ack");
    chk("R3 four bits left", {16'd0, win_data}, 32'h0000_000C);
    need_n = 5'd9;
    #1 chk("R6 valid low with 4 held", {31'd0, win_valid}, 32'd0);
    use_en = 1'b1; use_n = 5'd9;
    #1 chk("R6 refused 9 of 4", {31'd0, use_ack}, 32'd0);
    @(negedge clk);
    use_en = 1'b0;
    @(negedge clk);
    chk("R6 nothing shifted", {16'd0, win_data}, 32'h0000_000C);
    push(32'h1234_5678);
    repeat (3) @(negedge clk);
    #1 chk("R6 valid after refill", {31'd0, win_valid}, 32'd1);
    chk("R5 spliced window", {16'd0, win_data}, 32'h0000_678C);
    consume(9, "R6 ack after refill");
    consume(16, "R4 ack");
    // 11 bits held, queue empty
    need_n = 5'd9; src_done = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no error when request fits", {31'd0, err_underflow}, 32'd0);
    need_n = 5'd12;
    repeat (2) @(negedge clk);
    chk("R8 underflow raised", {31'd0, err_underflow}, 32'd1);
    need_n = 5'd0;
    repeat (2) @(negedge clk);
    chk("R8 underflow sticky", {31'd0, err_underflow}, 32'd1);

    // R3 little endian, R9 big endian
    do_reset();
    chk("R1 err cleared by reset", {31'd0, err_underflow}, 32'd0);
    push(32'h1122_3344);
    repeat (3) @(negedge clk);
    chk("R3 little endian bytes", {16'd0, win_data}, 32'h0000_3344);
    do_reset();
    big_endian = 1'b1;
    push(32'h1122_3344);
    big_endian = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 big endian bytes", {16'd0, win_data}, 32'h0000_2211);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule